// File: doc/BRIEF.md
# I2C Bus-Clear Recovery Sequencer

This block frees an I2C bus on which a slave has stopped partway through a byte and keeps SDA held low. After a single trigger it runs a fixed train of nine recovery cycles on the open-drain SCL and SDA lines. Nine cycles cover every bit position a stuck slave can be at, from the first data bit through the acknowledge. Every cycle opens with a START condition. A slave caught mid-read is released by the clock edges alone. A slave caught mid-write needs the START as well, so every cycle carries both.

The timing follows the bus rate. At trigger time the block takes the rate in kHz and works out a base delay in microseconds. That delay is the integer quotient 1000 / rate plus one, and it is never less than 2 us. Each cycle spends one base delay with the lines driven and two base delays with them released. A microsecond tick is derived from the system-clock parameter, and the phases count that tick. The outputs are open-drain enables: a 1 pulls the line low, and a 0 lets the external pull-up return it high. The control pins are plain level and pulse signals. No data stream passes through the block, so it has no valid/ready interface.

Top module: `i2c_busclr_seq`

## Requirements
- R1: One trigger produces exactly nine recovery cycles, and then the block stops driving.
- R2: Each cycle begins with a START. For 1 us `sda_oe_o`=1 while `scl_oe_o`=0, and then both are 1. SCL is never pulled low unless SDA is already pulled low.
- R3: The base delay B is 1000 / `rate_khz_i` + 1 us, using integer division. `rate_khz_i` is sampled on the trigger cycle only. The driven part of a cycle (START plus SCL low) lasts B us in total.
- R4: In the release phase of each cycle both enables are 0 for 2*B us. A full cycle therefore lasts 3*B us.
- R5: B never falls below 2 us. A rate of 0 gives B = 2, and so does any rate above 1000 kHz.
- R6: `busy_o` is 1 from the cycle after the trigger until the last release phase ends. `done_o` is a one-cycle pulse in the first cycle in which `busy_o` is 0 again.
- R7: A trigger that arrives while `busy_o` is 1 is ignored. It does not restart, lengthen or repeat the sequence.
- R8: Whenever `busy_o` is 0, including during and after reset, both enables are 0.
- R9: One microsecond equals CLK_HZ / 1,000,000 system-clock cycles. Every phase lasts exactly its length in microseconds multiplied by that count.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start_i | input | 1 | Trigger; sampled while idle |
| rate_khz_i | input | RATE_W | Bus clock rate in kHz; 0 selects the minimum delay |
| busy_o | output | 1 | Sequence in progress |
| done_o | output | 1 | One-cycle pulse when the sequence ends |
| scl_oe_o | output | 1 | 1 pulls SCL low |
| sda_oe_o | output | 1 | 1 pulls SDA low |

## Verification
The bench measures the length of every phase in system cycles, and it does this at several bus rates. One of those rates lands on the 2 us floor by the formula. Another is zero, and a third is above 1000 kHz, so it needs the clamp. A block that divides without the +1, or that skips the clamp, would give phases that are too short there. A block that forgets the START would pulse SCL without first pulling SDA low.

Two other faults are also checked. The rate is changed right after the trigger, which catches a block that reads the rate live instead of latching it. A trigger is held during a release phase, which catches a block that restarts its cycle count. Either fault shows up as a tenth START or as a busy signal that stays high too long.

// File: rtl/busclr_pkg.sv
package busclr_pkg;
  // Number of recovery cycles: eight data bits and the acknowledge slot
  localparam int NUM_CYCLES  = 9;
  // Floor on the base delay, in microseconds
  localparam int MIN_BASE_US = 2;
  // 1e6 us/s divided by (kHz * 1000) reduces to 1000 / kHz
  localparam int DIVIDEND    = 1000;
  localparam int QUO_W       = $clog2(DIVIDEND + 1);

  typedef enum logic [2:0] {
    PH_IDLE,
    PH_CALC,
    PH_START,
    PH_DRIVE,
    PH_REL
  } phase_e;
endpackage

// File: rtl/busclr_us_tick.sv
module busclr_us_tick #(
  parameter int TPU = 125
) (
  input  logic clk,
  input  logic rst_n,
  input  logic clr,
  input  logic run,
  output logic tick
);
  localparam int CW = (TPU > 1) ? $clog2(TPU) : 1;
  localparam logic [CW-1:0] LAST = CW'(TPU - 1);

  logic [CW-1:0] cnt;

  assign tick = run && (cnt == LAST);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt <= '0;
    end else if (clr) begin
      cnt <= '0;
    end else if (run) begin
      cnt <= tick ? '0 : cnt + 1'b1;
    end
  end
endmodule

// File: rtl/busclr_div.sv
module busclr_div #(
  parameter int N_W = 10,
  parameter int D_W = 12,
  parameter int NUM = 1000
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           go,
  input  logic [D_W-1:0] den,
  output logic           done,
  output logic [N_W-1:0] quo
);
  localparam int SW = $clog2(N_W + 1);
  localparam logic [N_W-1:0] NUM_V = N_W'(NUM);

  logic [D_W-1:0] rem;
  logic [D_W-1:0] den_q;
  logic [N_W-1:0] q;
  logic [SW-1:0]  left;
  logic [D_W:0]   trial;
  logic [D_W:0]   diff;
  logic           fits;

  assign trial = {rem, q[N_W-1]};
  assign diff  = trial - {1'b0, den_q};
  assign fits  = trial >= {1'b0, den_q};
  assign quo   = q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rem   <= '0;
      den_q <= '0;
      q     <= '0;
      left  <= '0;
      done  <= 1'b0;
    end else begin
      done <= 1'b0;
      if (go) begin
        rem   <= '0;
        q     <= NUM_V;
        den_q <= den;
        left  <= SW'(N_W);
      end else if (left != '0) begin
        rem  <= fits ? diff[D_W-1:0] : trial[D_W-1:0];
        q    <= {q[N_W-2:0], fits};
        left <= left - 1'b1;
        if (left == SW'(1)) done <= 1'b1;
      end
    end
  end
endmodule

// File: rtl/i2c_busclr_seq.sv
module i2c_busclr_seq #(
  parameter int CLK_HZ = 125_000_000,
  parameter int RATE_W = 12
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start_i,
  input  logic [RATE_W-1:0] rate_khz_i,
  output logic              busy_o,
  output logic              done_o,
  output logic              scl_oe_o,
  output logic              sda_oe_o
);
  import busclr_pkg::*;

  localparam int TPU    = (CLK_HZ / 1_000_000 > 0) ? CLK_HZ / 1_000_000 : 1;
  localparam int Q_W    = QUO_W;
  localparam int BASE_W = Q_W + 1;
  localparam int PH_W   = BASE_W + 1;
  localparam int CYC_W  = $clog2(NUM_CYCLES);
  localparam logic [BASE_W-1:0] MIN_B    = BASE_W'(MIN_BASE_US);
  localparam logic [CYC_W-1:0]  LAST_CYC = CYC_W'(NUM_CYCLES - 1);

  phase_e            state;
  logic [RATE_W-1:0] rate_q;
  logic [BASE_W-1:0] base_q;
  logic [BASE_W-1:0] base_raw;
  logic [BASE_W-1:0] base_nx;
  logic [PH_W-1:0]   us_cnt;
  logic [PH_W-1:0]   ph_len;
  logic [CYC_W-1:0]  cyc;
  logic              go;
  logic              div_done;
  logic [Q_W-1:0]    quo;
  logic              run;
  logic              tick;
  logic              ph_last;
  logic              advance;
  logic              clr;

  assign go = (state == PH_IDLE) && start_i;

  busclr_div #(
    .N_W (Q_W),
    .D_W (RATE_W),
    .NUM (DIVIDEND)
  ) u_div (
    .clk   (clk),
    .rst_n (rst_n),
    .go    (go),
    .den   (rate_khz_i),
    .done  (div_done),
    .quo   (quo)
  );

  assign base_raw = {1'b0, quo} + 1'b1;
  assign base_nx  = ((rate_q == '0) || (base_raw < MIN_B)) ? MIN_B : base_raw;

  assign run = (state == PH_START) || (state == PH_DRIVE) || (state == PH_REL);

  always_comb begin
    case (state)
      PH_DRIVE: ph_len = {1'b0, base_q} - 1'b1;
      PH_REL:   ph_len = {base_q, 1'b0};
      default:  ph_len = PH_W'(1);
    endcase
  end

  assign ph_last = (us_cnt == ph_len - 1'b1);
  assign advance = run && tick && ph_last;
  assign clr     = ((state == PH_CALC) && div_done) || advance;

  busclr_us_tick #(
    .TPU (TPU)
  ) u_tick (
    .clk   (clk),
    .rst_n (rst_n),
    .clr   (clr),
    .run   (run),
    .tick  (tick)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state  <= PH_IDLE;
      rate_q <= '0;
      base_q <= MIN_B;
      us_cnt <= '0;
      cyc    <= '0;
      done_o <= 1'b0;
    end else begin
      done_o <= 1'b0;
      if (advance) begin
        us_cnt <= '0;
      end else if (run && tick) begin
        us_cnt <= us_cnt + 1'b1;
      end
      case (state)
        PH_IDLE: begin
          if (start_i) begin
            rate_q <= rate_khz_i;
            state  <= PH_CALC;
          end
        end
        PH_CALC: begin
          if (div_done) begin
            base_q <= base_nx;
            cyc    <= '0;
            us_cnt <= '0;
            state  <= PH_START;
          end
        end
        PH_START: if (advance) state <= PH_DRIVE;
        PH_DRIVE: if (advance) state <= PH_REL;
        PH_REL: begin
          if (advance) begin
            if (cyc == LAST_CYC) begin
              state  <= PH_IDLE;
              done_o <= 1'b1;
            end else begin
              cyc   <= cyc + 1'b1;
              state <= PH_START;
            end
          end
        end
        default: state <= PH_IDLE;
      endcase
    end
  end

  assign busy_o   = (state != PH_IDLE);
  assign sda_oe_o = (state == PH_START) || (state == PH_DRIVE);
  assign scl_oe_o = (state == PH_DRIVE);
endmodule

// File: rtl/busclr_chk.sv
module busclr_chk (
  input logic clk,
  input logic rst_n,
  input logic busy_o,
  input logic done_o,
  input logic scl_oe_o,
  input logic sda_oe_o
);
  logic [3:0] starts;
  logic       sda_prev;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      starts   <= '0;
      sda_prev <= 1'b0;
    end else begin
      sda_prev <= sda_oe_o;
      if (done_o) starts <= '0;
      else if (sda_oe_o && !sda_prev) starts <= starts + 1'b1;
    end
  end

  assert_nine_at_end_R1: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |-> (starts == 4'd9));

  assert_no_tenth_R1: assert property (@(posedge clk) disable iff (!rst_n)
    starts <= 4'd9);

  assert_scl_after_sda_R2: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(scl_oe_o) |-> (sda_oe_o && $past(sda_oe_o)));

  assert_start_with_scl_high_R2: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(sda_oe_o) |-> !scl_oe_o);

  assert_done_single_R6: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |=> !done_o);

  assert_done_after_busy_R6: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |-> (!busy_o && $past(busy_o)));

  assert_idle_released_R8: assert property (@(posedge clk) disable iff (!rst_n)
    !busy_o |-> (!scl_oe_o && !sda_oe_o));
endmodule

bind i2c_busclr_seq busclr_chk u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .busy_o   (busy_o),
  .done_o   (done_o),
  .scl_oe_o (scl_oe_o),
  .sda_oe_o (sda_oe_o)
);

// File: tb/i2c_busclr_seq_test.sv
module i2c_busclr_seq_test;
  localparam int CLK_HZ = 4_000_000;
  localparam int TPU    = 4;
  localparam int RW     = 12;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          start = 1'b0;
  logic [RW-1:0] rate = '0;
  logic          busy, done, scl, sda;
  int            n_chk = 0;
  int            n_fail = 0;

  always #4 clk = ~clk;

  i2c_busclr_seq #(.CLK_HZ(CLK_HZ), .RATE_W(RW)) uut (
    .clk        (clk),
    .rst_n      (rst_n),
    .start_i    (start),
    .rate_khz_i (rate),
    .busy_o     (busy),
    .done_o     (done),
    .scl_oe_o   (scl),
    .sda_oe_o   (sda)
  );

  task automatic check(input bit ok, input string req, input string what,
                       input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  task automatic seg(input logic [1:0] pat, output int n);
    n = 0;
    while ({scl, sda} == pat && busy && n < 20000) begin
      n++;
      @(negedge clk);
    end
  endtask

  task automatic run_seq(input int r, input bit poke);
    int b, n, total;
    b = (r == 0) ? 2 : 1000 / r + 1;
    if (b < 2) b = 2;
    total = 0;
    @(negedge clk);
    rate  = RW'(r);
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    rate  = RW'(1);
    check(busy == 1'b1, "R6", "busy after trigger", int'(busy), 1);
    seg(2'b00, n);
    for (int k = 0; k < 9; k++) begin
      seg(2'b01, n);
      check(n == TPU, "R2", "START hold cycles", n, TPU);
      total += n;
      seg(2'b11, n);
      check(n == (b - 1) * TPU, "R3", "SCL-low cycles", n, (b - 1) * TPU);
      total += n;
      if (poke && k == 4) start = 1'b1;
      seg(2'b00, n);
      start = 1'b0;
      check(n == 2 * b * TPU, "R4", "release cycles", n, 2 * b * TPU);
      total += n;
      if (k < 8) check(busy == 1'b1, "R1", "busy between cycles", int'(busy), 1);
    end
    check(busy == 1'b0, "R1", "busy after nine cycles", int'(busy), 0);
    check(done == 1'b1, "R6", "done pulse", int'(done), 1);
    check(total == 27 * b * TPU, "R9", "sequence length", total, 27 * b * TPU);
    @(negedge clk);
    check(done == 1'b0, "R6", "done one cycle", int'(done), 0);
    for (int i = 0; i < 20; i++) begin
      if (busy || scl || sda) begin
        check(1'b0, "R8", "idle lines", {busy, scl, sda}, 0);
        break;
      end
      @(negedge clk);
    end
    check(!busy, poke ? "R7" : "R8", "stays idle", int'(busy), 0);
  endtask

  task automatic t_reset;
    @(negedge clk);
    check({busy, done, scl, sda} == 4'b0, "R8", "reset outputs", {busy, done, scl, sda}, 0);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    check({busy, done, scl, sda} == 4'b0, "R8", "idle after reset", {busy, done, scl, sda}, 0);
  endtask

  task automatic t_rate_375;    run_seq(375, 1'b0);  endtask // R3 R9: B = 3
  task automatic t_rate_zero;   run_seq(0, 1'b0);    endtask // R5: B = 2
  task automatic t_rate_clamp;  run_seq(3400, 1'b0); endtask // R5: 0+1 -> 2
  task automatic t_rate_1000;   run_seq(1000, 1'b0); endtask // R3: B = 2
  task automatic t_rate_100;    run_seq(100, 1'b0);  endtask // R3: B = 11
  task automatic t_rate_20;     run_seq(20, 1'b0);   endtask // R3: B = 51
  task automatic t_busy_trig;   run_seq(375, 1'b1);  endtask // R7

  task automatic summary;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
  endtask

  initial begin
    t_reset();
    t_rate_375();
    t_rate_zero();
    t_rate_clamp();
    t_rate_1000();
    t_rate_100();
    t_rate_20();
    t_busy_trig();
    summary();
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    n_chk++;
    n_fail++;
    $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
    summary();
    $finish;
  end
endmodule